// File: doc/BRIEF.md
# Direct-Mapped Cache with Run-Time Write Policy

This block is a small direct-mapped data cache that sits between a processor load/store port and a slower main memory that moves one word per transfer. Each byte address is split into three parts. The lowest bits pick the byte and the word inside a line. The next bits pick one of the lines. The upper bits form the tag, which is stored beside the line. A read that hits is answered from the line array. A miss refills the whole line from memory and replaces whatever line was held at that index.

A mode input chooses at run time how stores reach memory. In write-through mode each store updates the line and also writes the word to memory, and the processor is held until memory acknowledges the write. In write-back mode a store only updates the line and marks it modified. Memory sees the data later, when that modified line is pushed out by a conflicting access. Stores that miss allocate the line first in both modes and then merge the stored word into it.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_busy`, `cpu_done` and `mem_req` are low, and the first access to any address misses and reads memory.
- R2: Address bits [1:0] are the byte within a word, bit [2] picks the word in a two-word line, bits [4:3] pick one of four lines, and the bits above form the tag. A read hit returns the cached word with no memory traffic, and `cpu_done` is high at the second clock edge after the edge that accepted the request.
- R3: A miss reads the full line from memory: word 0 at the line base, then word 1 at base+4. After that, a read of either word in the line hits.
- R4: An access whose index matches a valid line with a different tag replaces that line. The displaced address then misses again.
- R5: In write-through mode (`wb_mode`=0) a store hit updates the line and issues exactly one memory write of that word to its address. `cpu_done` comes only after that write is acknowledged.
- R6: In write-back mode (`wb_mode`=1) a store hit updates the line, issues no memory traffic and marks the line modified. Memory keeps its old value.
- R7: A miss on a modified line first writes both victim words (word 0, then word 1, at the victim's own address) and only then starts the refill reads. A miss on an unmodified line issues reads only.
- R8: A store miss refills the line and then merges the stored word into it, in both modes. The other word of the line keeps its memory value.
- R9: `mem_req` stays asserted with stable address, direction and write data until `mem_ack`. Each acknowledge completes one word.
- R10: The cache accepts `cpu_req` only while `cpu_busy` is low. `cpu_busy` stays high from acceptance until completion, and `cpu_done` is a one-cycle pulse that carries valid `cpu_rdata` for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | Store policy: 1 write-back, 0 write-through |
| cpu_req | input | 1 | Access request, sampled while not busy |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Access in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
A read hit must raise `cpu_done` exactly two clock edges after the accepting edge. The bench counts falling edges from the request and requires a count of two on every hit. Misses and write-through stores finish a variable number of cycles later, because they wait on the memory model's latency. For these the bench waits for `cpu_done` and then checks the memory transfers, all of which are logged before that pulse, in both order and content. The scoreboard monitor samples `cpu_done` and `cpu_rdata` on falling edges and pops the expected word queued by the driver before the request.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_EVICT,
      ST_FILL,
      ST_WTHRU,
      ST_DONE
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 4,
   parameter int TAG_W = 7,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             install,
   input  logic [TAG_W-1:0] new_tag,
   input  logic             mark_dirty,
   output logic [TAG_W-1:0] tag_out,
   output logic             valid_out,
   output logic             dirty_out
);
   logic [LINES-1:0] valid_vec;
   logic [LINES-1:0] dirty_vec;
   logic [TAG_W-1:0] tag_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic             v_q;
      logic             d_q;
      logic [TAG_W-1:0] t_q;
      logic             sel;
      assign sel = (idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
         end else if (sel && install) begin
            v_q <= 1'b1;
            d_q <= 1'b0;
            t_q <= new_tag;
         end else if (sel && mark_dirty) begin
            d_q <= 1'b1;
         end
      end
      assign valid_vec[i] = v_q;
      assign dirty_vec[i] = d_q;
      assign tag_arr[i]   = t_q;
   end

   assign tag_out   = tag_arr[idx];
   assign valid_out = valid_vec[idx];
   assign dirty_out = dirty_vec[idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int LINES  = 4,
   parameter int WORDS  = 2,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_en,
   input  logic [WSEL_W-1:0] wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [WSEL_W-1:0] rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words_q [LINES][WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) words_q[idx][wr_sel] <= wr_data;
   end

   assign rd_data = words_q[idx][rd_sel];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int LINES  = 4,
   parameter int WORDS  = 2,
   localparam int WOFF_W = $clog2(DATA_W / 8),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - WOFF_W - WSEL_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_mode,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              cpu_busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   // tag store side
   output logic [IDX_W-1:0]  line_idx,
   output logic              ts_install,
   output logic [TAG_W-1:0]  ts_new_tag,
   output logic              ts_mark_dirty,
   input  logic [TAG_W-1:0]  ts_tag,
   input  logic              ts_valid,
   input  logic              ts_dirty,
   // data store side
   output logic              ds_wr_en,
   output logic [WSEL_W-1:0] ds_wr_sel,
   output logic [DATA_W-1:0] ds_wr_data,
   output logic [WSEL_W-1:0] ds_rd_sel,
   input  logic [DATA_W-1:0] ds_rd_data
);
   localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

   dmc_state_e state_q, state_d;
   logic [ADDR_W-WOFF_W-1:0] wa_q;
   logic                     we_q;
   logic [DATA_W-1:0]        wd_q;
   logic [WSEL_W-1:0]        cnt_q;
   logic [DATA_W-1:0]        rdata_q;

   logic [TAG_W-1:0]  req_tag;
   logic [WSEL_W-1:0] req_wsel;
   logic              hit;
   logic              last;
   logic              unused_low;

   assign unused_low = ^cpu_addr[WOFF_W-1:0];
   assign req_wsel   = wa_q[WSEL_W-1:0];
   assign line_idx   = wa_q[WSEL_W +: IDX_W];
   assign req_tag    = wa_q[ADDR_W-WOFF_W-1 -: TAG_W];
   assign hit        = ts_valid && (ts_tag == req_tag);
   assign last       = (cnt_q == LAST_WORD);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (cpu_req) state_d = ST_LOOK;
         ST_LOOK: begin
            if (hit)                   state_d = (we_q && !wb_mode) ? ST_WTHRU : ST_DONE;
            else if (ts_valid && ts_dirty) state_d = ST_EVICT;
            else                       state_d = ST_FILL;
         end
         ST_EVICT: if (mem_ack && last) state_d = ST_FILL;
         ST_FILL:  if (mem_ack && last) state_d = ST_LOOK;
         ST_WTHRU: if (mem_ack) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wa_q    <= '0;
         we_q    <= 1'b0;
         wd_q    <= '0;
         cnt_q   <= '0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req) begin
            wa_q <= cpu_addr[ADDR_W-1:WOFF_W];
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
         end
         if (state_q == ST_LOOK) cnt_q <= '0;
         else if ((state_q == ST_EVICT || state_q == ST_FILL) && mem_ack)
            cnt_q <= last ? '0 : cnt_q + 1'b1;
         if (state_q == ST_LOOK && hit && !we_q) rdata_q <= ds_rd_data;
      end
   end

   // line array and tag array updates
   always_comb begin
      ds_wr_en      = 1'b0;
      ds_wr_sel     = req_wsel;
      ds_wr_data    = wd_q;
      ts_install    = 1'b0;
      ts_mark_dirty = 1'b0;
      if (state_q == ST_FILL && mem_ack) begin
         ds_wr_en   = 1'b1;
         ds_wr_sel  = cnt_q;
         ds_wr_data = mem_rdata;
         ts_install = last;
      end else if (state_q == ST_LOOK && hit && we_q) begin
         ds_wr_en      = 1'b1;
         ts_mark_dirty = wb_mode;
      end
   end
   assign ts_new_tag = req_tag;
   assign ds_rd_sel  = (state_q == ST_EVICT) ? cnt_q : req_wsel;

   // memory side
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state_q)
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {ts_tag, line_idx, cnt_q, {WOFF_W{1'b0}}};
            mem_wdata = ds_rd_data;
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {req_tag, line_idx, cnt_q, {WOFF_W{1'b0}}};
         end
         ST_WTHRU: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {wa_q, {WOFF_W{1'b0}}};
            mem_wdata = wd_q;
         end
         default: ;
      endcase
   end

   assign cpu_busy  = (state_q != ST_IDLE);
   assign cpu_done  = (state_q == ST_DONE);
   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int LINES  = 4,
   parameter int WORDS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_mode,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              cpu_busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int WOFF_W = $clog2(DATA_W / 8);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - WOFF_W - WSEL_W - IDX_W;

   if (DATA_W < 16 || (DATA_W % 8) != 0 || ((DATA_W / 8) & (DATA_W / 8 - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power-of-two byte count of at least two bytes");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr_w
      $error("ADDR_W leaves no tag bits");
   end

   logic [IDX_W-1:0]  line_idx;
   logic              ts_install, ts_mark_dirty, ts_valid, ts_dirty;
   logic [TAG_W-1:0]  ts_new_tag, ts_tag;
   logic              ds_wr_en;
   logic [WSEL_W-1:0] ds_wr_sel, ds_rd_sel;
   logic [DATA_W-1:0] ds_wr_data, ds_rd_data;

   dmc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_done(cpu_done), .cpu_busy(cpu_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .line_idx(line_idx), .ts_install(ts_install), .ts_new_tag(ts_new_tag),
      .ts_mark_dirty(ts_mark_dirty), .ts_tag(ts_tag), .ts_valid(ts_valid),
      .ts_dirty(ts_dirty),
      .ds_wr_en(ds_wr_en), .ds_wr_sel(ds_wr_sel), .ds_wr_data(ds_wr_data),
      .ds_rd_sel(ds_rd_sel), .ds_rd_data(ds_rd_data)
   );

   dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
      .clk(clk), .rst_n(rst_n), .idx(line_idx),
      .install(ts_install), .new_tag(ts_new_tag), .mark_dirty(ts_mark_dirty),
      .tag_out(ts_tag), .valid_out(ts_valid), .dirty_out(ts_dirty)
   );

   dmc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) data_i (
      .clk(clk), .idx(line_idx),
      .wr_en(ds_wr_en), .wr_sel(ds_wr_sel), .wr_data(ds_wr_data),
      .rd_sel(ds_rd_sel), .rd_data(ds_rd_data)
   );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_done,
   input logic              cpu_busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   // R1: reset holds the port quiet
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!cpu_busy && !mem_req && !cpu_done)
            else $error("outputs active during reset");
      end
   end

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
      else $error("memory request changed before acknowledge");

   assert_mem_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_busy)
      else $error("memory traffic while idle");

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done)
      else $error("completion longer than one cycle");

   assert_done_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !mem_req)
      else $error("completion with memory transfer open");

   assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_busy |=> cpu_busy)
      else $error("request not accepted");
endmodule

bind dm_cache dmc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
   .cpu_busy(cpu_busy), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/dm_cache_tb_top.sv
module dm_cache_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int DATA_W     = 32;
   localparam int MEM_LAT    = 3;
   localparam int MEM_WORDS  = 1024;
   localparam int LOG_MAX    = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wb_mode = 1'b0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              cpu_done, cpu_busy;
   logic              mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_ack = 1'b0;
   logic [DATA_W-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   dm_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_done(cpu_done), .cpu_busy(cpu_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   function automatic logic [DATA_W-1:0] init_val(int a);
      return 32'h5000_0000 | a;
   endfunction

   // memory model with transfer log
   logic [DATA_W-1:0] mem [MEM_WORDS];
   int                lat_cnt = 0;
   int                log_n = 0;
   bit                log_we [LOG_MAX];
   int                log_addr [LOG_MAX];
   logic [DATA_W-1:0] log_data [LOG_MAX];

   initial begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = init_val(i * 4);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt == MEM_LAT - 1) begin
            lat_cnt <= 0;
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[ADDR_W-1:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[ADDR_W-1:2]];
            if (log_n < LOG_MAX) begin
               log_we[log_n]   <= mem_we;
               log_addr[log_n] <= int'(mem_addr);
               log_data[log_n] <= mem_we ? mem_wdata : mem[mem_addr[ADDR_W-1:2]];
            end
            log_n <= log_n + 1;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      bit                is_read;
      logic [DATA_W-1:0] data;
      string             req;
   } exp_t;
   exp_t exp_q[$];

   always @(negedge clk) begin
      if (rst_n && cpu_done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10", "completion without request", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.is_read) check(cpu_rdata == e.data, e.req, "read data", cpu_rdata, e.data);
         end
      end
   end

   int last_cyc;
   int last_base;

   task automatic access(input bit we, input int addr, input logic [DATA_W-1:0] wdata,
                         input logic [DATA_W-1:0] exp_rd, input string req);
      exp_t e;
      int cyc;
      e.is_read = !we;
      e.data    = exp_rd;
      e.req     = req;
      @(negedge clk);
      exp_q.push_back(e);
      last_base = log_n;
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = ADDR_W'(addr);
      cpu_wdata = wdata;
      @(negedge clk);
      cpu_req = 1'b0;
      cyc = 1;
      while (!cpu_done && cyc < 500) begin
         @(negedge clk);
         cyc++;
      end
      check(cpu_done, "R10", "completion seen", 32'(cpu_done), 32'd1);
      last_cyc = cyc;
   endtask

   task automatic traffic_count(input string req, input int n);
      check(log_n - last_base == n, req, "memory transfer count",
            32'(log_n - last_base), 32'(n));
   endtask

   task automatic traffic_at(input string req, input int k, input bit we, input int addr,
                             input logic [DATA_W-1:0] data);
      int j;
      j = last_base + k;
      check(log_we[j] == we, req, $sformatf("transfer %0d direction", k),
            32'(log_we[j]), 32'(we));
      check(log_addr[j] == addr, req, $sformatf("transfer %0d address", k),
            32'(log_addr[j]), 32'(addr));
      if (we) check(log_data[j] == data, req, $sformatf("transfer %0d data", k),
                    log_data[j], data);
   endtask

   task automatic hit_read(input int addr, input logic [DATA_W-1:0] exp, input string req);
      access(1'b0, addr, '0, exp, req);
      traffic_count(req, 0);
      check(last_cyc == 2, req, "hit latency", 32'(last_cyc), 32'd2);
   endtask

   // watchdog
   initial begin
      wait (cycles > 20000);
      check(1'b0, "WDOG", "watchdog expired", 32'(cycles), 32'd20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!cpu_busy && !cpu_done && !mem_req, "R1", "outputs during reset",
            {29'd0, cpu_busy, cpu_done, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cpu_busy && !mem_req, "R1", "outputs after reset",
            {30'd0, cpu_busy, mem_req}, 32'd0);

      // write-through mode
      wb_mode = 1'b0;
      // R1, R3: first access misses and fetches both words of line 1
      access(1'b0, 1000, '0, init_val(1000), "R3");
      traffic_count("R1", 2);
      traffic_at("R3", 0, 1'b0, 1000, '0);
      traffic_at("R3", 1, 1'b0, 1004, '0);
      // R2, R3: neighbour word now hits
      hit_read(1004, init_val(1004), "R2");
      // R1: untouched line 0 misses
      access(1'b0, 1024, '0, init_val(1024), "R1");
      traffic_count("R1", 2);
      // R4: 1040 and 1008 share line 2
      access(1'b0, 1040, '0, init_val(1040), "R4");
      traffic_count("R4", 2);
      access(1'b0, 1008, '0, init_val(1008), "R4");
      traffic_count("R4", 2);
      traffic_at("R4", 0, 1'b0, 1008, '0);
      traffic_at("R7", 1, 1'b0, 1012, '0);
      access(1'b0, 1040, '0, init_val(1040), "R4");
      traffic_count("R4", 2);
      traffic_at("R4", 0, 1'b0, 1040, '0);
      // R5: write-through store hit
      access(1'b1, 1044, 32'hDEAD_0001, '0, "R5");
      traffic_count("R5", 1);
      traffic_at("R5", 0, 1'b1, 1044, 32'hDEAD_0001);
      check(mem[1044 >> 2] == 32'hDEAD_0001, "R5", "memory after store",
            mem[1044 >> 2], 32'hDEAD_0001);
      hit_read(1044, 32'hDEAD_0001, "R5");
      // R8: write-through store miss allocates then writes
      access(1'b1, 1016, 32'h1111_2222, '0, "R8");
      traffic_count("R8", 3);
      traffic_at("R8", 0, 1'b0, 1016, '0);
      traffic_at("R8", 1, 1'b0, 1020, '0);
      traffic_at("R5", 2, 1'b1, 1016, 32'h1111_2222);
      hit_read(1016, 32'h1111_2222, "R8");
      hit_read(1020, init_val(1020), "R8");

      // write-back mode
      @(negedge clk);
      wb_mode = 1'b1;
      // R6: store hits touch only the line
      access(1'b1, 1000, 32'hAAAA_0000, '0, "R6");
      traffic_count("R6", 0);
      access(1'b1, 1004, 32'hBBBB_0004, '0, "R6");
      traffic_count("R6", 0);
      check(mem[1000 >> 2] == init_val(1000), "R6", "memory unchanged",
            mem[1000 >> 2], init_val(1000));
      hit_read(1000, 32'hAAAA_0000, "R6");
      // R7: conflicting read pushes out both modified words first
      access(1'b0, 1032, '0, init_val(1032), "R7");
      traffic_count("R7", 4);
      traffic_at("R7", 0, 1'b1, 1000, 32'hAAAA_0000);
      traffic_at("R7", 1, 1'b1, 1004, 32'hBBBB_0004);
      traffic_at("R7", 2, 1'b0, 1032, '0);
      traffic_at("R7", 3, 1'b0, 1036, '0);
      // R8, R7: store miss on a clean line, no victim writes
      access(1'b1, 1064, 32'hCCCC_0000, '0, "R8");
      traffic_count("R7", 2);
      traffic_at("R8", 0, 1'b0, 1064, '0);
      traffic_at("R8", 1, 1'b0, 1068, '0);
      hit_read(1068, init_val(1068), "R8");
      hit_read(1064, 32'hCCCC_0000, "R8");
      // R7: dirty victim written back, then the evicted data returns from memory
      access(1'b0, 1000, '0, 32'hAAAA_0000, "R7");
      traffic_count("R7", 4);
      traffic_at("R7", 0, 1'b1, 1064, 32'hCCCC_0000);
      traffic_at("R7", 1, 1'b1, 1068, init_val(1068));
      traffic_at("R7", 2, 1'b0, 1000, '0);
      traffic_at("R7", 3, 1'b0, 1004, '0);

      // R9: memory request closed once idle
      @(negedge clk);
      check(!mem_req && !cpu_busy, "R9", "idle after accesses",
            {30'd0, mem_req, cpu_busy}, 32'd0);
      check(exp_q.size() == 0, "R10", "scoreboard drained", 32'(exp_q.size()), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule